// File: doc/BRIEF.md
# Bus Cycle Sequencer with Wait States

This block produces the T-state timing of a processor's external bus machine cycles. A client hands it one cycle at a time (opcode fetch, memory read, memory write, I/O read or I/O write) with an address and, for writes, a data byte. The sequencer then steps through the T-states of that cycle on the clock, one T-state per clock. It drives the address bus, the active-low strobes and the write data. It captures read data and reports completion with a one-clock done pulse.

Slow devices stretch a cycle by holding `wait_n` low at the sampling point. I/O cycles always carry one extra automatic state. Every opcode fetch ends with a two-state refresh phase. In that phase the low address byte carries a 7-bit refresh counter and the high byte carries the interrupt vector register value. The sequencer also returns the fetch address plus one as the next program-counter value.

States: `S_IDLE`, `S_T1`, `S_T2`, `S_TA` (automatic I/O wait), `S_TW` (requested wait), `S_T3`, `S_R1`, `S_R2` (refresh). The transitions are:
- IDLE→T1 on an accepted request.
- T1→T2.
- T2→TA for I/O cycles.
- T2→TW for memory cycles when `wait_n` is low.
- T2→R1 for a fetch when `wait_n` is high.
- T2→T3 for other memory cycles when `wait_n` is high.
- TA→TW when `wait_n` is low, otherwise TA→T3.
- TW→TW while `wait_n` is low. When it is high, TW→R1 for a fetch and TW→T3 otherwise.
- T3→IDLE.
- R1→R2.
- R2→IDLE.

Top module: `busseq_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, all six strobes are high, `req_ready` is 1, `rsp_done` is 0 and `fetch_pc_next` is 0. Asserting reset in the middle of a cycle returns the block to idle.
- R2: A memory read (`req_kind` 1; codes 5 to 7 are also treated as memory read) with no waits lasts 3 T-states. `mreq_n` and `rd_n` are low in all of them, and `bus_addr` equals the request address. `rsp_data` is the `bus_din` value present in the last T-state.
- R3: A memory write (`req_kind` 2) with no waits lasts 3 T-states. `mreq_n` is low in all of them, `wr_n` is low from the second one on, and `rd_n` stays high. While `wr_n` is low, `bus_dout_en` is 1 and `bus_dout` is the write byte.
- R4: In memory cycles `wait_n` is sampled at the end of T2. Each low sample adds one wait state, and `wait_n` is sampled again at the end of each wait state.
- R5: I/O read (`req_kind` 3) and I/O write (`req_kind` 4) last 4 T-states plus requested waits. One automatic state always follows T2, and the first `wait_n` sample is taken in it. `iorq_n` and `rd_n`/`wr_n` are low from the second T-state to the last. `mreq_n` stays high.
- R6: An opcode fetch (`req_kind` 0) lasts 4 T-states plus waits. `m1_n`, `mreq_n` and `rd_n` are low in T1, T2 and any wait states. The data byte is taken from `bus_din` in the last of those states.
- R7: Each fetch ends with exactly two refresh states. In them `rfsh_n` and `mreq_n` are low and `m1_n`, `rd_n` are high. `bus_addr[15:8]` is `vec_reg`, `bus_addr[7]` is the held top bit of the refresh register (0 after reset), and `bus_addr[6:0]` is the refresh counter.
- R8: The refresh counter is 0 after reset and advances by one after each fetch only. It wraps from 127 to 0 within its 7 bits.
- R9: After a fetch, `fetch_pc_next` equals the fetch address plus one, modulo 2^16.
- R10: `req_ready` is high only when idle, and a request is accepted only then. `rsp_done` is a one-clock pulse in the first idle cycle after each cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cycle request present |
| req_kind | input | 3 | 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write |
| req_addr | input | 16 | Cycle address (program counter for a fetch) |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Sequencer idle, request accepted this edge |
| rsp_data | output | 8 | Captured read data |
| rsp_done | output | 1 | One-clock completion pulse |
| fetch_pc_next | output | 16 | Fetch address plus one after a fetch |
| vec_reg | input | 8 | Interrupt vector value for the refresh high byte |
| wait_n | input | 1 | Active-low wait request |
| bus_din | input | 8 | Data bus input |
| bus_addr | output | 16 | Address bus |
| bus_dout | output | 8 | Data bus output |
| bus_dout_en | output | 1 | Data bus output enable |
| mreq_n | output | 1 | Memory request, active low |
| iorq_n | output | 1 | I/O request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m1_n | output | 1 | Opcode fetch marker, active low |
| rfsh_n | output | 1 | Refresh marker, active low |

## Verification
The bench drives `wait_n` low for several T-states at the sampling points. This shows whether the wait was sampled in the wrong T-state: a design that did so would be one state short or long. I/O cycles with and without waits separate the automatic state from requested ones. A design that skipped it, or sampled `wait_n` in T2 for I/O, gives the wrong length and the wrong `iorq_n` count. More than 128 consecutive fetches push the refresh counter through its wrap. A counter that carried into bit 7, or advanced on non-fetch cycles, shows a wrong refresh address. A fetch at address FFFF checks the program-counter wrap, and a reset in the middle of a cycle checks the return to idle.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_T1,
        S_T2,
        S_TA,
        S_TW,
        S_T3,
        S_R1,
        S_R2
    } state_e;

    // Unknown request codes fall back to a plain memory read.
    function automatic kind_e decode_kind(input logic [2:0] code);
        kind_e k;
        unique case (code)
            3'd0:    k = K_FETCH;
            3'd2:    k = K_MWR;
            3'd3:    k = K_IORD;
            3'd4:    k = K_IOWR;
            default: k = K_MRD;
        endcase
        return k;
    endfunction

    function automatic logic kind_is_io(input kind_e k);
        return (k == K_IORD) || (k == K_IOWR);
    endfunction

    function automatic logic kind_is_read(input kind_e k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
    endfunction

    function automatic logic kind_is_write(input kind_e k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

endpackage

// File: rtl/busseq_refresh.sv
module busseq_refresh #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W:0]   rreg
);
    // Low CNT_W bits count refreshes; the top bit is held as it is.
    logic [CNT_W-1:0] cnt_q;
    logic             top_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            top_q <= 1'b0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
            top_q <= top_q;
        end
    end

    assign rreg = {top_q, cnt_q};
endmodule

// File: rtl/busseq_fsm.sv
module busseq_fsm
    import busseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wait_n,
    input  logic [DATA_W-1:0] bus_din,
    output state_e            state,
    output kind_e             kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_done,
    output logic [ADDR_W-1:0] fetch_pc_next,
    output logic              rfsh_step
);
    state_e state_q, state_nx;
    logic   is_fetch, is_io, capture;

    assign is_fetch = (kind_q == K_FETCH);
    assign is_io    = kind_is_io(kind_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) state_nx = S_T1;
            S_T1:   state_nx = S_T2;
            S_T2: begin
                if (is_io)        state_nx = S_TA;
                else if (!wait_n) state_nx = S_TW;
                else if (is_fetch) state_nx = S_R1;
                else              state_nx = S_T3;
            end
            S_TA:   state_nx = wait_n ? S_T3 : S_TW;
            S_TW: begin
                if (!wait_n)       state_nx = S_TW;
                else if (is_fetch) state_nx = S_R1;
                else               state_nx = S_T3;
            end
            S_T3:   state_nx = S_IDLE;
            S_R1:   state_nx = S_R2;
            S_R2:   state_nx = S_IDLE;
        endcase
    end

    // Read data is taken at the edge that ends the last strobed state.
    assign capture = ((state_q == S_T3) && kind_is_read(kind_q)) ||
                     (is_fetch && (state_q == S_T2 || state_q == S_TW) &&
                      (state_nx == S_R1));

    // Request latch, response and program-counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q        <= K_MRD;
            addr_q        <= '0;
            wdata_q       <= '0;
            rsp_data      <= '0;
            rsp_done      <= 1'b0;
            fetch_pc_next <= '0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                kind_q  <= decode_kind(req_kind);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rsp_data <= bus_din;
            rsp_done <= (state_q == S_T3) || (state_q == S_R2);
            if (state_q == S_R2) fetch_pc_next <= addr_q + 1'b1;
        end
    end

    assign rfsh_step = (state_q == S_R2);
    assign state     = state_q;
endmodule

// File: rtl/busseq_strobes.sv
module busseq_strobes
    import busseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RREG_W = 8
) (
    input  state_e                   state,
    input  kind_e                    kind_q,
    input  logic [ADDR_W-1:0]        addr_q,
    input  logic [DATA_W-1:0]        wdata_q,
    input  logic [RREG_W-1:0]        rreg,
    input  logic [ADDR_W-RREG_W-1:0] vec_reg,
    output logic                     req_ready,
    output logic [ADDR_W-1:0]        bus_addr,
    output logic [DATA_W-1:0]        bus_dout,
    output logic                     bus_dout_en,
    output logic                     mreq_n,
    output logic                     iorq_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     m1_n,
    output logic                     rfsh_n
);
    logic ph_main, ph_late, ph_rfsh, ph_idle;
    logic k_io, k_rd, k_wr, k_fetch;

    assign k_io    = kind_is_io(kind_q);
    assign k_rd    = kind_is_read(kind_q);
    assign k_wr    = kind_is_write(kind_q);
    assign k_fetch = (kind_q == K_FETCH);

    // Output process: phase flags decoded from the state
    always_comb begin
        ph_main = 1'b0;
        ph_late = 1'b0;
        ph_rfsh = 1'b0;
        ph_idle = 1'b0;
        unique case (state)
            S_IDLE: ph_idle = 1'b1;
            S_T1:   ph_main = 1'b1;
            S_T2, S_TA, S_TW, S_T3: begin
                ph_main = 1'b1;
                ph_late = 1'b1;
            end
            S_R1, S_R2: ph_rfsh = 1'b1;
        endcase

        req_ready   = ph_idle;
        mreq_n      = !((!k_io && ph_main) || ph_rfsh);
        iorq_n      = !(k_io && ph_late);
        rd_n        = !(k_rd && (k_io ? ph_late : ph_main));
        wr_n        = !(k_wr && ph_late);
        m1_n        = !(k_fetch && ph_main);
        rfsh_n      = !ph_rfsh;
        bus_dout_en = k_wr && ph_main;
        bus_dout    = wdata_q;
        bus_addr    = ph_rfsh ? {vec_reg, rreg} : addr_q;
    end
endmodule

// File: rtl/busseq_top.sv
module busseq_top
    import busseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RCNT_W = 7,
    localparam int RREG_W = RCNT_W + 1,
    localparam int VEC_W  = ADDR_W - RREG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_done,
    output logic [ADDR_W-1:0] fetch_pc_next,
    input  logic [VEC_W-1:0]  vec_reg,
    input  logic              wait_n,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    output logic              mreq_n,
    output logic              iorq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              m1_n,
    output logic              rfsh_n
);
    state_e              state;
    kind_e               kind_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                rfsh_step;
    logic [RREG_W-1:0]   rreg;

    busseq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .wait_n(wait_n),
        .bus_din(bus_din), .state(state), .kind_q(kind_q), .addr_q(addr_q),
        .wdata_q(wdata_q), .rsp_data(rsp_data), .rsp_done(rsp_done),
        .fetch_pc_next(fetch_pc_next), .rfsh_step(rfsh_step)
    );

    busseq_refresh #(.CNT_W(RCNT_W)) rfsh_i (
        .clk(clk), .rst_n(rst_n), .step(rfsh_step), .rreg(rreg)
    );

    busseq_strobes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RREG_W(RREG_W)) strb_i (
        .state(state), .kind_q(kind_q), .addr_q(addr_q), .wdata_q(wdata_q),
        .rreg(rreg), .vec_reg(vec_reg), .req_ready(req_ready),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
        .m1_n(m1_n), .rfsh_n(rfsh_n)
    );
endmodule

// File: rtl/busseq_chk.sv
module busseq_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mreq_n,
    input logic             iorq_n,
    input logic             rd_n,
    input logic             wr_n,
    input logic             m1_n,
    input logic             rfsh_n,
    input logic             req_ready,
    input logic             rsp_done,
    input logic [VEC_W-1:0] addr_hi,
    input logic [VEC_W-1:0] vec_reg
);
    p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_mem_io_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mreq_n && !iorq_n));

    p_m1_rfsh_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!m1_n && !rfsh_n));

    p_rfsh_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_n |-> (addr_hi == vec_reg && !mreq_n));

    p_rfsh_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rfsh_n) |=> !rfsh_n);

    p_rfsh_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rfsh_n && $past(!rfsh_n)) |=> rfsh_n);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mreq_n && iorq_n && rd_n && wr_n && m1_n && rfsh_n));
endmodule

bind busseq_top busseq_chk #(.VEC_W(VEC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n),
    .req_ready(req_ready), .rsp_done(rsp_done),
    .addr_hi(bus_addr[ADDR_W-1:ADDR_W-VEC_W]), .vec_reg(vec_reg)
);

// File: tb/busseq_top_tb_top.sv
module busseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        req_ready;
    logic [7:0]  rsp_data;
    logic        rsp_done;
    logic [15:0] fetch_pc_next;
    logic [7:0]  vec_reg = 8'h5C;
    logic        wait_n = 1'b1;
    logic [7:0]  bus_din = 8'h0;
    logic [15:0] bus_addr;
    logic [7:0]  bus_dout;
    logic        bus_dout_en;
    logic        mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n;

    int checks = 0;
    int errors = 0;
    int rcnt   = 0;   // model of the refresh counter
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    busseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_data(rsp_data), .rsp_done(rsp_done), .fetch_pc_next(fetch_pc_next),
        .vec_reg(vec_reg), .wait_n(wait_n), .bus_din(bus_din),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
        .m1_n(m1_n), .rfsh_n(rfsh_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit strobes_idle();
        return mreq_n && iorq_n && rd_n && wr_n && m1_n && rfsh_n;
    endfunction

    // kind, addr, wdata, din, waits, expected T-states
    localparam logic [42:0] TBL [11] = '{
        {3'd1, 16'h1234, 8'h00, 8'hA5, 4'd0, 4'd3},
        {3'd2, 16'h8001, 8'h3C, 8'h00, 4'd0, 4'd3},
        {3'd0, 16'h0100, 8'h00, 8'h3E, 4'd0, 4'd4},
        {3'd3, 16'h00FE, 8'h00, 8'h77, 4'd0, 4'd4},
        {3'd4, 16'h0003, 8'hC3, 8'h00, 4'd0, 4'd4},
        {3'd1, 16'h4000, 8'h00, 8'h5A, 4'd2, 4'd5},
        {3'd2, 16'hC000, 8'h81, 8'h00, 4'd3, 4'd6},
        {3'd0, 16'h2000, 8'h00, 8'hED, 4'd1, 4'd5},
        {3'd3, 16'h1210, 8'h00, 8'h19, 4'd2, 4'd6},
        {3'd4, 16'h0055, 8'hAA, 8'h00, 4'd1, 4'd5},
        {3'd7, 16'h7777, 8'h00, 8'h42, 4'd0, 4'd3}
    };

    task automatic run_cycle(input logic [2:0] kind, input logic [15:0] addr,
                             input logic [7:0] wd, input logic [7:0] din,
                             input int nw, input int exp_len);
        bit    is_io    = (kind == 3'd3) || (kind == 3'd4);
        bit    is_fetch = (kind == 3'd0);
        bit    is_wr    = (kind == 3'd2) || (kind == 3'd4);
        string tag      = is_fetch ? "R6" : is_io ? "R5" : is_wr ? "R3" : "R2";
        int    first_w  = is_io ? 3 : 2;
        int t = 0, n_mreq = 0, n_iorq = 0, n_rd = 0, n_wr = 0, n_m1 = 0, n_rf = 0;
        int bad_addr = 0, bad_dout = 0, bad_rf = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
        bus_din = din; wait_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && t < 40) begin
            t++;
            wait_n = !(t >= first_w && t < first_w + nw);
            if (!mreq_n) n_mreq++;
            if (!iorq_n) n_iorq++;
            if (!rd_n)   n_rd++;
            if (!wr_n)   n_wr++;
            if (!m1_n)   n_m1++;
            if (!rfsh_n) begin
                n_rf++;
                if (bus_addr != {vec_reg, 1'b0, 7'(rcnt)}) bad_rf++;
            end else if (bus_addr != addr) bad_addr++;
            if (!wr_n && !(bus_dout_en && bus_dout == wd)) bad_dout++;
            @(negedge clk);
        end
        wait_n = 1'b1;
        check(t == exp_len, (nw > 0) ? "R4" : tag, "T-state count", t, exp_len);
        check(bad_addr == 0, tag, "address during cycle", bad_addr, 0);
        check(rsp_done == 1'b1, "R10", "done pulse at idle", rsp_done, 1);
        if (is_io) begin
            check(n_iorq == exp_len - 1 && n_mreq == 0, "R5", "iorq/mreq count",
                  n_iorq, exp_len - 1);
            if (is_wr) check(n_wr == exp_len - 1 && n_rd == 0, "R5", "wr count", n_wr, exp_len - 1);
            else       check(n_rd == exp_len - 1 && n_wr == 0, "R5", "rd count", n_rd, exp_len - 1);
        end else if (is_fetch) begin
            check(n_m1 == exp_len - 2 && n_rd == exp_len - 2, "R6", "m1/rd count", n_m1, exp_len - 2);
            check(n_mreq == exp_len, "R6", "mreq count", n_mreq, exp_len);
            check(n_rf == 2 && bad_rf == 0, "R7", "refresh states/address", n_rf * 16 + bad_rf, 32);
            check(fetch_pc_next == addr + 16'd1, "R9", "next pc", fetch_pc_next, addr + 16'd1);
            rcnt = (rcnt + 1) % 128;
        end else begin
            check(n_mreq == exp_len && n_iorq == 0 && n_rf == 0, tag, "mreq count", n_mreq, exp_len);
            if (is_wr) check(n_wr == exp_len - 1 && n_rd == 0, "R3", "wr count", n_wr, exp_len - 1);
            else       check(n_rd == exp_len && n_wr == 0, "R2", "rd count", n_rd, exp_len);
        end
        if (is_wr) check(bad_dout == 0, tag, "write data on bus", bad_dout, 0);
        else       check(rsp_data == din, tag, "read data", rsp_data, din);
        @(negedge clk);
        check(rsp_done == 1'b0, "R10", "done lasts one cycle", rsp_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(strobes_idle() && req_ready && !rsp_done && fetch_pc_next == 16'h0,
              "R1", "reset state", {mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n}, 6'h3F);
        rst_n = 1'b1;
        @(negedge clk);
        check(strobes_idle() && req_ready && !rsp_done, "R1", "first idle cycle",
              req_ready, 1);

        foreach (TBL[i]) begin
            logic [42:0] e = TBL[i];
            run_cycle(e[42:40], e[39:24], e[23:16], e[15:8], int'(e[7:4]), int'(e[3:0]));
        end

        // R9: program-counter wrap
        run_cycle(3'd0, 16'hFFFF, 8'h00, 8'h11, 0, 4);

        // R8: refresh counter wraps inside seven bits
        vec_reg = 8'hA7;
        for (int i = 0; i < 130; i++) run_cycle(3'd0, 16'(i), 8'h00, 8'(i), 0, 4);
        check(rcnt < 128, "R8", "model wrap", rcnt, 0);

        // R10: busy means not ready
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h0F0F;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R10", "ready low while busy", req_ready, 0);
        // R1: reset in mid-cycle
        rst_n = 1'b0;
        @(negedge clk);
        check(strobes_idle() && req_ready && !rsp_done, "R1", "reset mid-cycle",
              {mreq_n, rd_n}, 2'b11);
        rst_n = 1'b1;
        rcnt = 0;
        run_cycle(3'd0, 16'h3000, 8'h00, 8'h66, 0, 4);

        ended = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!ended) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule